// File: doc/BRIEF.md
# Pin Event Detector with Grouped Interrupts

This block watches a bank of general-purpose input pins and records events on them. Each pin can be armed for any mix of six detection classes: synchronous rising edge, synchronous falling edge, high level, low level, and early (first-stage) rising and falling edges. A pin that sees an armed condition sets its bit in an event status word. That bit stays set until software writes a one to it.

Status bits are ORed into three interrupt lines, each serving a fixed contiguous range of pins. Those ranges straddle the 32-bit word boundary of the register layout. Software arms pins and clears events through a simple read/write register port. The CPU-side interrupt controller lies outside this block.

Raw pin levels enter through a two-flop synchronizer, followed by one extra history stage. Synchronous edges compare the second and third stages. Early edges compare the first and second stages, so they are seen one cycle sooner.

Top module: `pin_event_unit`

## Requirements
- R1: After reset every enable word and both status words read zero, and all three interrupt lines are low.
- R2: Register map by byte address, with pin n at word n/32, bit n%32. Status words are at 0x40 and 0x44. The enable word pairs are rising 0x4C/0x50, falling 0x58/0x5C, high 0x64/0x68, low 0x70/0x74, early rising 0x7C/0x80 and early falling 0x88/0x8C. A read returns data with `rvalid` one cycle after `rd_en`. Bits for pins that do not exist read zero.
- R3: With a synchronous edge enable set, a matching pin change first sampled at clock edge E sets the status bit after edge E+2. A change of the other polarity sets nothing.
- R4: Setting both the rising and falling enables of a pin makes it flag either edge.
- R5: With a level enable set, the status bit is set on every cycle the synchronized pin holds that level. A clear written in such a cycle loses to the new detection.
- R6: With an early edge enable set, a matching change first sampled at edge E sets the status bit after edge E+1.
- R7: Writing a one to a status bit clears it. Writing a zero leaves the bit unchanged.
- R8: A status bit stays set after its enable is cleared, until it is explicitly cleared.
- R9: Interrupt line 0 covers pins 0 to 27. Line 1 covers pins 28 to 45 (word 0 bits 28 to 31 and word 1 bits 0 to 13). Line 2 covers pins 46 to 53 (word 1 bits 14 to 21).
- R10: Each interrupt line is registered and rises one cycle after a status bit in its range becomes set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| pin_i | input | 54 | Raw pin levels |
| irq_o | output | 3 | Grouped interrupt lines |

## Verification
The hardest case to reach from the ports is a clear write that coincides with an active level detection. It only shows up if the pin is held at its level with the enable armed while the write lands. The stimulus therefore parks a pin high with its high-level enable set and issues the clear in that state, then reads the bit back. The range edges of the interrupt lines are also awkward to hit. Pins 27, 28, 45, 46 and 53 are armed for early rising edges and pulsed one at a time, and the full three-line vector is checked after each pulse. The edge latencies are checked cycle by cycle on the interrupt line relative to the sampling edge.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  typedef enum logic [2:0] {
    CLS_RISE  = 3'd0,
    CLS_FALL  = 3'd1,
    CLS_HIGH  = 3'd2,
    CLS_LOW   = 3'd3,
    CLS_ARISE = 3'd4,
    CLS_AFALL = 3'd5
  } det_class_e;

  localparam int NUM_CLASSES  = 6;
  localparam int STATUS_BASE  = 'h40;
  localparam int CLASS_BASE   = 'h4C;
  localparam int CLASS_STRIDE = 'h0C;
  localparam int NUM_LINES    = 3;
endpackage

// File: rtl/pin_event_sync.sv
module pin_event_sync #(
  parameter int N = 54
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] arise_o,
  output logic [N-1:0] afall_o
);
  logic [N-1:0] st1_q, st2_q, st3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1_q <= '0;
      st2_q <= '0;
      st3_q <= '0;
    end else begin
      st1_q <= pin_i;
      st2_q <= st1_q;
      st3_q <= st2_q;
    end
  end

  assign level_o = st2_q;
  assign rise_o  = st2_q & ~st3_q;
  assign fall_o  = ~st2_q & st3_q;
  assign arise_o = st1_q & ~st2_q;
  assign afall_o = ~st1_q & st2_q;
endmodule

// File: rtl/pin_event_status.sv
module pin_event_status #(
  parameter int N = 54
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] det_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_i) | det_i;
  end

  assign status_o = status_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    |(clr_i & ~det_i) |=> ((status_q & $past(clr_i & ~det_i)) == '0)); // R7
  AST_DET_WINS: assert property (@(posedge clk) disable iff (rst)
    |det_i |=> ((status_q & $past(det_i)) == $past(det_i))); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_q) & ~$past(clr_i) & ~status_q) == '0)); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(det_i)) == '0)); // R3
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq #(
  parameter int N       = 54,
  parameter int L0_LAST = 27,
  parameter int L1_LAST = 45
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status_i,
  output logic [2:0]   irq_o
);
  function automatic logic [N-1:0] span(input int lo, input int hi);
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

  localparam logic [N-1:0] M0 = span(0, L0_LAST);
  localparam logic [N-1:0] M1 = span(L0_LAST + 1, L1_LAST);
  localparam logic [N-1:0] M2 = span(L1_LAST + 1, N - 1);

  logic [2:0] irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= {|(status_i & M2), |(status_i & M1), |(status_i & M0)};
  end

  assign irq_o = irq_q;

  AST_LINE0_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o[0]) |-> $past(|status_i[L0_LAST:0])); // R9
  AST_LINE2_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o[2]) |-> $past(|status_i[N-1:L1_LAST+1])); // R9
  AST_LINE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (|status_i[L1_LAST:L0_LAST+1]) |=> irq_o[1]); // R10
endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
  import pin_event_pkg::*;
#(
  parameter int N       = 54,
  parameter int L0_LAST = 27,
  parameter int L1_LAST = 45
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [7:0]   addr,
  input  logic [31:0]  wdata,
  output logic [31:0]  rdata,
  output logic         rvalid,
  input  logic [53:0]  pin_i,
  output logic [2:0]   irq_o
);
  localparam int WORDS = (N + 31) / 32;

  logic [N-1:0] en_q [NUM_CLASSES];
  logic [N-1:0] cond [NUM_CLASSES];
  logic [N-1:0] lvl, rise, fall, arise, afall;
  logic [N-1:0] det, clr, status;
  logic [NUM_CLASSES-1:0][WORDS-1:0] cls_hit;
  logic [WORDS-1:0] st_hit;
  logic [31:0] rword;

  pin_event_sync #(.N(N)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i[N-1:0]),
    .level_o(lvl), .rise_o(rise), .fall_o(fall),
    .arise_o(arise), .afall_o(afall)
  );

  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++)
      for (int w = 0; w < WORDS; w++)
        cls_hit[c][w] = (int'(addr) == CLASS_BASE + c * CLASS_STRIDE + w * 4);
    for (int w = 0; w < WORDS; w++)
      st_hit[w] = (int'(addr) == STATUS_BASE + w * 4);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CLASSES; c++) en_q[c] <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CLASSES; c++)
        for (int i = 0; i < N; i++)
          if (cls_hit[c][i / 32]) en_q[c][i] <= wdata[i % 32];
    end
  end

  always_comb begin
    cond[int'(CLS_RISE)]  = rise;
    cond[int'(CLS_FALL)]  = fall;
    cond[int'(CLS_HIGH)]  = lvl;
    cond[int'(CLS_LOW)]   = ~lvl;
    cond[int'(CLS_ARISE)] = arise;
    cond[int'(CLS_AFALL)] = afall;
    det = '0;
    for (int c = 0; c < NUM_CLASSES; c++) det = det | (en_q[c] & cond[c]);
    for (int i = 0; i < N; i++) clr[i] = wr_en & st_hit[i / 32] & wdata[i % 32];
  end

  pin_event_status #(.N(N)) u_status (
    .clk(clk), .rst(rst), .det_i(det), .clr_i(clr), .status_o(status)
  );

  pin_event_irq #(.N(N), .L0_LAST(L0_LAST), .L1_LAST(L1_LAST)) u_irq (
    .clk(clk), .rst(rst), .status_i(status), .irq_o(irq_o)
  );

  always_comb begin
    rword = '0;
    for (int i = 0; i < N; i++) begin
      if (st_hit[i / 32]) rword[i % 32] = status[i];
      for (int c = 0; c < NUM_CLASSES; c++)
        if (cls_hit[c][i / 32]) rword[i % 32] = en_q[c][i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? rword : '0;
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == 3'b000 && !rvalid)); // R1
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (en_q[int'(CLS_HIGH)] == $past(en_q[int'(CLS_HIGH)]))); // R8
endmodule

// File: tb/pin_event_unit_tb.sv
module pin_event_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [53:0] pin_i = '0;
  logic [2:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] val; string req; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  pin_event_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pin_i(pin_i), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    if (rvalid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected read data %h, expected none", rdata);
      end else begin
        e = sb.pop_front();
        if (rdata !== e.val) begin
          errors++;
          $display("FAIL %s: read %h expected %h", e.req, rdata, e.val);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string req);
    exp_t x;
    x.val = e; x.req = req;
    @(negedge clk); rd_en = 1'b1; addr = 8'(a); sb.push_back(x);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic [2:0] e, input string req);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq %b expected %b", req, irq_o, e);
    end
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); pin_i[p] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk_irq(3'b000, "R1");
    for (int a = 'h40; a <= 'h8C; a += 4)
      if (a != 'h48 && a != 'h54 && a != 'h60 && a != 'h6C && a != 'h78 && a != 'h84)
        rd(a, 32'h0, "R1");

    // R2: nonexistent pins read zero in upper word
    wr('h50, 32'hFFFF_FFFF);
    rd('h50, 32'h003F_FFFF, "R2");
    wr('h50, 32'h0);

    // R3 + R10: synchronous rising on pin 3, exact latency
    wr('h4C, 32'h8);
    @(negedge clk); pin_i[3] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); chk_irq(3'b000, "R3 latency");
    @(posedge clk); @(negedge clk); chk_irq(3'b001, "R10 latency");
    rd('h40, 32'h8, "R3");
    set_pin(3, 1'b0); idle(5);
    rd('h40, 32'h8, "R3 opposite edge ignored");
    wr('h40, 32'h0);
    rd('h40, 32'h8, "R7 zero write");
    wr('h40, 32'h8);
    rd('h40, 32'h0, "R7 clear");
    idle(2); chk_irq(3'b000, "R7 irq drops");
    wr('h4C, 32'h0);

    // R3: synchronous falling on pin 5
    wr('h58, 32'h20);
    set_pin(5, 1'b1); idle(5);
    rd('h40, 32'h0, "R3 rise ignored by fall enable");
    set_pin(5, 1'b0); idle(5);
    rd('h40, 32'h20, "R3 fall");
    wr('h40, 32'h20); wr('h58, 32'h0);

    // R4: both edges on pin 40 (word1 bit8)
    wr('h50, 32'h100); wr('h5C, 32'h100);
    set_pin(40, 1'b1); idle(5);
    rd('h44, 32'h100, "R4 rise");
    chk_irq(3'b010, "R4 irq");
    wr('h44, 32'h100);
    set_pin(40, 1'b0); idle(5);
    rd('h44, 32'h100, "R4 fall");
    wr('h50, 32'h0); wr('h5C, 32'h0); wr('h44, 32'h100);

    // R6 + R10: early rising on pin 30, exact latency
    wr('h7C, 32'h4000_0000);
    @(negedge clk); pin_i[30] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); chk_irq(3'b000, "R6 latency");
    @(posedge clk); @(negedge clk); chk_irq(3'b010, "R6 irq");
    rd('h40, 32'h4000_0000, "R6 rise");
    // R8: disable enable, bit stays
    wr('h7C, 32'h0); idle(3);
    rd('h40, 32'h4000_0000, "R8 sticky");
    wr('h40, 32'h4000_0000);
    // R6: early falling
    wr('h88, 32'h4000_0000);
    set_pin(30, 1'b0); idle(4);
    rd('h40, 32'h4000_0000, "R6 fall");
    wr('h88, 32'h0); wr('h40, 32'h4000_0000);

    // R5: level high on pin 50 (word1 bit18), clear loses
    set_pin(50, 1'b1);
    wr('h68, 32'h0004_0000); idle(3);
    wr('h44, 32'h0004_0000);
    rd('h44, 32'h0004_0000, "R5 clear loses");
    chk_irq(3'b100, "R5 irq2");
    wr('h68, 32'h0); wr('h44, 32'h0004_0000);
    rd('h44, 32'h0, "R5 cleared after disable");
    set_pin(50, 1'b0);

    // R5: level low on pin 0
    wr('h70, 32'h1); idle(3);
    rd('h40, 32'h1, "R5 low level");
    set_pin(0, 1'b1); idle(4);
    wr('h40, 32'h1);
    rd('h40, 32'h0, "R5 low not active while high");
    wr('h70, 32'h0); set_pin(0, 1'b0);
    idle(3); chk_irq(3'b000, "R5 quiet");

    // R9: line boundaries
    wr('h7C, 32'h1800_0000);
    wr('h80, 32'h0020_6000);
    begin
      int pins[5] = '{27, 28, 45, 46, 53};
      logic [2:0] lines[5] = '{3'b001, 3'b010, 3'b010, 3'b100, 3'b100};
      foreach (pins[k]) begin
        set_pin(pins[k], 1'b1); idle(4);
        chk_irq(lines[k], "R9 boundary");
        set_pin(pins[k], 1'b0);
        wr('h40, 32'hFFFF_FFFF); wr('h44, 32'hFFFF_FFFF);
        idle(3);
        chk_irq(3'b000, "R9 cleared");
      end
    end
    wr('h7C, 32'h0); wr('h80, 32'h0);

    idle(4);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d reads unanswered, expected 0", sb.size());
    end
    finish_run();
  end
endmodule